// File: doc/BRIEF.md
# Keyed Watchdog Countdown Timer

This block is a watchdog for a system controller. Software sets a reload value and turns the timer on through a small word-addressed register window. From then on a counter steps down once per selected tick. The tick is either a 1 MHz tick-enable or a tick-enable from a slower clock. To keep the system alive, software must write one exact key word to the restart register. Any other word is discarded.

If the counter is allowed to run out, the block fires the timeout actions that the control register enables, each as a single-cycle pulse. The actions are a system reset request, an interrupt and a trigger for an external reset pulse generator. The counter then reloads and keeps running. A level output carries the reset-scope choice (full chip or processor subsystem only) to the reset controller.

Tick generation, shaping of the external reset pulse and any timeout-status bookkeeping are outside this block.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the count and the reload register both hold 0x03EF1480, the control register holds 0, and all pulse outputs and `rst_full_chip` are 0.
- R2: Reads decode the byte address as follows. 0x00 returns the live count. 0x04 returns the reload value. 0x08 always returns 0. 0x0C returns control bits [5:0], with bits [31:6] read as 0. Writes to 0x00 do not change the count.
- R3: A write of exactly 0x00004755 to 0x08 copies the reload value into the count. Any other written value leaves the count unchanged.
- R4: Control bit 0 is the run enable. A control write that changes it from 0 to 1 loads the count from the reload value. A write that leaves it at 1 does not reload. While it is 0, the count holds its value.
- R5: Control bit 4 selects the tick. When it is 1, `tick_1mhz` is counted and `tick_slow` is ignored. When it is 0, the opposite applies.
- R6: While running, each cycle with the selected tick high lowers the count by one. A tick that arrives while the count is 0 is a timeout. On a timeout the count reloads from the reload value, so the timeout period is reload+1 ticks. No timeout occurs while run is 0.
- R7: A timeout drives a one-cycle pulse in the clock cycle after the timeout tick on each enabled output: `sysrst_pulse` when control bit 1 is set, `irq_pulse` when bit 2 is set, and `extrst_pulse` when bit 3 is set.
- R8: `rst_full_chip` follows control bit 5. A value of 1 means full-chip reset scope and 0 means the processor subsystem only.
- R9: A key restart or a run-enable rising write in the same cycle as a selected tick takes priority. The count takes the reload value, with no decrement and no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1mhz | input | 1 | 1 MHz tick-enable, one cycle wide |
| tick_slow | input | 1 | Tick-enable from the slower clock, one cycle wide |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid during a read request |
| irq_pulse | output | 1 | Timeout interrupt pulse |
| sysrst_pulse | output | 1 | Timeout system reset request pulse |
| extrst_pulse | output | 1 | Trigger for the external reset pulse generator |
| rst_full_chip | output | 1 | Reset scope: 1 full chip, 0 processor subsystem only |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a tick landing exactly when the key restart is written. The other is a tick landing when run is switched on while the count already sits at zero. In both cases the write must win and no timeout may fire. The bench walks the count down to zero with counted ticks, then raises the tick in the same cycle as the bus write. It then checks that the count equals the reload value and that no pulse appears. It also stops the timer at a zero count to show that ticks in that state are ignored.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int DATA_W = 32;
  localparam int N_ACT  = 3;

  localparam int OFS_STATUS  = 'h00;
  localparam int OFS_RELOAD  = 'h04;
  localparam int OFS_RESTART = 'h08;
  localparam int OFS_CTRL    = 'h0C;

  localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_4755;
  localparam logic [DATA_W-1:0] RELOAD_INIT = 32'h03EF_1480;

  // control word, bit 5 down to bit 0
  typedef struct packed {
    logic full_chip;
    logic fast_tick;
    logic ext_en;
    logic irq_en;
    logic sys_en;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic key_match(input logic [DATA_W-1:0] d);
    return d == RESTART_KEY;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
    return {{(DATA_W-CTRL_W){1'b0}}, c};
  endfunction

  function automatic logic is_expiry(input logic [DATA_W-1:0] cnt, input logic step);
    return step && (cnt == '0);
  endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  reload_q,
  output ctrl_t             ctrl_q,
  output logic              restart_hit,
  output logic              run_rise,
  output logic [DATA_W-1:0] bus_rdata
);
  logic wr, rd;
  logic sel_status, sel_reload, sel_restart, sel_ctrl;
  ctrl_t ctrl_new;

  assign wr = bus_valid && bus_write;
  assign rd = bus_valid && !bus_write;

  assign sel_status  = bus_addr == ADDR_W'(OFS_STATUS);
  assign sel_reload  = bus_addr == ADDR_W'(OFS_RELOAD);
  assign sel_restart = bus_addr == ADDR_W'(OFS_RESTART);
  assign sel_ctrl    = bus_addr == ADDR_W'(OFS_CTRL);

  assign ctrl_new    = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  assign restart_hit = wr && sel_restart && key_match(bus_wdata);
  assign run_rise    = wr && sel_ctrl && ctrl_new.run && !ctrl_q.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= CNT_W'(RELOAD_INIT);
      ctrl_q   <= '0;
    end else if (wr) begin
      if (sel_reload) reload_q <= bus_wdata[CNT_W-1:0];
      if (sel_ctrl)   ctrl_q   <= ctrl_new;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (sel_status) bus_rdata = DATA_W'(count_q);
      if (sel_reload) bus_rdata = DATA_W'(reload_q);
      if (sel_ctrl)   bus_rdata = ctrl_word(ctrl_q);
    end
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
  import kwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fast_sel,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             restart_hit,
  input  logic             run_rise,
  output logic [CNT_W-1:0] count_q,
  output logic             tick_sel,
  output logic             expire
);
  logic load, step;

  assign tick_sel = fast_sel ? tick_fast : tick_slow;
  assign load     = restart_hit || run_rise;
  assign step     = run && tick_sel && !load;
  assign expire   = is_expiry(DATA_W'(count_q), step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count_q <= CNT_W'(RELOAD_INIT);
    else if (load || expire) count_q <= reload_val;
    else if (step)           count_q <= count_q - CNT_W'(1);
  end
endmodule

// File: rtl/kwd_actions.sv
module kwd_actions #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         expire,
  input  logic [N-1:0] act_en,
  output logic [N-1:0] pulse_q
);
  for (genvar i = 0; i < N; i++) begin : g_act
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q[i] <= 1'b0;
      else        pulse_q[i] <= expire && act_en[i];
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1mhz,
  input  logic              tick_slow,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse,
  output logic              sysrst_pulse,
  output logic              extrst_pulse,
  output logic              rst_full_chip
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] reload_q;
  ctrl_t            ctrl_q;
  logic             ctrl_run;
  logic             restart_hit, run_rise, expire, tick_sel;
  logic [N_ACT-1:0] act_en, pulses;

  assign ctrl_run = ctrl_q.run;

  kwd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .count_q(count_q), .reload_q(reload_q), .ctrl_q(ctrl_q),
    .restart_hit(restart_hit), .run_rise(run_rise),
    .bus_rdata(bus_rdata)
  );

  kwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .run(ctrl_q.run), .fast_sel(ctrl_q.fast_tick),
    .tick_fast(tick_1mhz), .tick_slow(tick_slow),
    .reload_val(reload_q), .restart_hit(restart_hit), .run_rise(run_rise),
    .count_q(count_q), .tick_sel(tick_sel), .expire(expire)
  );

  assign act_en = {ctrl_q.ext_en, ctrl_q.irq_en, ctrl_q.sys_en};

  kwd_actions #(.N(N_ACT)) u_act (
    .clk(clk), .rst_n(rst_n),
    .expire(expire), .act_en(act_en), .pulse_q(pulses)
  );

  assign sysrst_pulse  = pulses[0];
  assign irq_pulse     = pulses[1];
  assign extrst_pulse  = pulses[2];
  assign rst_full_chip = ctrl_q.full_chip;
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CNT_W-1:0]  count_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic              ctrl_run,
  input logic              restart_hit,
  input logic              run_rise,
  input logic              tick_sel,
  input logic              expire,
  input logic              irq_pulse,
  input logic              sysrst_pulse
);
  logic wr_restart;
  assign wr_restart = bus_valid && bus_write && bus_addr == ADDR_W'(OFS_RESTART);

  p_key_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_restart && bus_wdata == RESTART_KEY) |=> count_q == $past(reload_q));

  p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_restart && bus_wdata != RESTART_KEY && !ctrl_run) |=> $stable(count_q));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_run && !restart_hit && !run_rise) |=> $stable(count_q));

  p_enable_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_rise |=> count_q == $past(reload_q));

  p_expire_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count_q == $past(reload_q));

  p_expire_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (ctrl_run && tick_sel && count_q == '0));

  p_irq_after_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(expire));

  p_sys_after_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_pulse |-> $past(expire));

  p_restart_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_hit || run_rise) |-> !expire);

  always @(posedge clk) begin
    if (rst_n && bus_valid && !bus_write && bus_addr == ADDR_W'(OFS_RESTART))
      p_restart_reads_zero_r2: assert (bus_rdata == '0);
  end
endmodule

bind keyed_wdog kwd_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .count_q(count_q), .reload_q(reload_q), .ctrl_run(ctrl_run),
  .restart_hit(restart_hit), .run_rise(run_rise),
  .tick_sel(tick_sel), .expire(expire),
  .irq_pulse(irq_pulse), .sysrst_pulse(sysrst_pulse)
);

// File: tb/keyed_wdog_test.sv
module keyed_wdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1mhz = 1'b0, tick_slow = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pulse, sysrst_pulse, extrst_pulse, rst_full_chip;
  int total = 0, bad = 0;

  localparam logic [7:0] A_STAT = 8'h00, A_REL = 8'h04, A_RST = 8'h08, A_CTL = 8'h0C;
  localparam logic [31:0] KEY = 32'h0000_4755;

  always #10 clk = ~clk;

  keyed_wdog uut (
    .clk(clk), .rst_n(rst_n), .tick_1mhz(tick_1mhz), .tick_slow(tick_slow),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .sysrst_pulse(sysrst_pulse),
    .extrst_pulse(extrst_pulse), .rst_full_chip(rst_full_chip)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic tick(input bit fast);
    @(negedge clk);
    if (fast) tick_1mhz = 1'b1; else tick_slow = 1'b1;
    @(negedge clk);
    tick_1mhz = 1'b0; tick_slow = 1'b0;
  endtask

  // pulses as {ext, irq, sys}
  function automatic logic [31:0] pulses();
    return {29'd0, extrst_pulse, irq_pulse, sysrst_pulse};
  endfunction

  task automatic t_reset;
    rd_chk("R1 status", A_STAT, 32'h03EF1480);
    rd_chk("R1 reload", A_REL, 32'h03EF1480);
    rd_chk("R1 ctrl", A_CTL, 32'h0);
    chk("R1 outputs", {pulses()[2:0], rst_full_chip}, 32'h0);
  endtask

  task automatic t_map;
    wr(A_REL, 32'h10);
    rd_chk("R2 reload rw", A_REL, 32'h10);
    wr(A_STAT, 32'h55);
    rd_chk("R2 status write ignored", A_STAT, 32'h03EF1480);
    wr(A_CTL, 32'hFFFF_FFC0);
    rd_chk("R2 ctrl upper bits", A_CTL, 32'h0);
    wr(A_RST, KEY);
    rd_chk("R2 restart reads zero", A_RST, 32'h0);
  endtask

  task automatic t_key;
    rd_chk("R3 key reload", A_STAT, 32'h10);
    wr(A_REL, 32'h20);
    wr(A_RST, 32'h0000_4756);
    rd_chk("R3 wrong key", A_STAT, 32'h10);
    wr(A_RST, 32'h0001_4755);
    rd_chk("R3 upper bits in key", A_STAT, 32'h10);
    wr(A_RST, KEY);
    rd_chk("R3 key again", A_STAT, 32'h20);
  endtask

  task automatic t_enable;
    wr(A_REL, 32'd7);
    wr(A_CTL, 32'h01);
    rd_chk("R4 enable reloads", A_STAT, 32'd7);
    tick(0);
    rd_chk("R6 slow tick decrements", A_STAT, 32'd6);
    tick(1);
    rd_chk("R5 fast tick ignored", A_STAT, 32'd6);
    wr(A_CTL, 32'h11);
    rd_chk("R4 no reload while run stays set", A_STAT, 32'd6);
    tick(1);
    rd_chk("R5 fast tick counted", A_STAT, 32'd5);
    tick(0);
    rd_chk("R5 slow tick ignored", A_STAT, 32'd5);
    wr(A_CTL, 32'h10);
    tick(1); tick(1);
    rd_chk("R4 disabled holds", A_STAT, 32'd5);
    wr(A_CTL, 32'h11);
    rd_chk("R4 re-enable reloads", A_STAT, 32'd7);
  endtask

  task automatic t_timeout;
    wr(A_REL, 32'd2);
    wr(A_CTL, 32'h00);
    wr(A_CTL, 32'h0F);
    rd_chk("R4 run rise", A_STAT, 32'd2);
    tick(0);
    tick(0);
    chk("R6 no pulse at reaching zero", pulses(), 32'h0);
    rd_chk("R6 count zero", A_STAT, 32'd0);
    tick(0);
    chk("R7 all actions pulse", pulses(), 32'h7);
    @(negedge clk);
    chk("R7 pulse one cycle", pulses(), 32'h0);
    rd_chk("R6 reload after timeout", A_STAT, 32'd2);
    wr(A_CTL, 32'h05);
    repeat (3) tick(0);
    chk("R7 irq only", pulses(), 32'h2);
    wr(A_CTL, 32'h0B);
    repeat (3) tick(0);
    chk("R7 sys and ext only", pulses(), 32'h5);
    tick(0); tick(0);
    wr(A_CTL, 32'h0E);
    tick(0);
    chk("R6 no timeout while stopped", pulses(), 32'h0);
    rd_chk("R4 hold at zero", A_STAT, 32'd0);
  endtask

  task automatic t_prio;
    wr(A_REL, 32'd3);
    wr(A_CTL, 32'h00);
    wr(A_CTL, 32'h05);
    repeat (3) tick(0);
    rd_chk("R9 setup zero", A_STAT, 32'd0);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_RST; bus_wdata = KEY; tick_slow = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; tick_slow = 1'b0;
    chk("R9 restart beats tick: no pulse", pulses(), 32'h0);
    rd_chk("R9 restart beats tick: count", A_STAT, 32'd3);
    repeat (3) tick(0);
    wr(A_CTL, 32'h04);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_CTL; bus_wdata = 32'h05; tick_slow = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; tick_slow = 1'b0;
    chk("R9 run rise beats tick: no pulse", pulses(), 32'h0);
    rd_chk("R9 run rise beats tick: count", A_STAT, 32'd3);
  endtask

  task automatic t_scope;
    wr(A_CTL, 32'h20);
    chk("R8 full chip scope", {31'd0, rst_full_chip}, 32'h1);
    wr(A_CTL, 32'h00);
    chk("R8 subsystem scope", {31'd0, rst_full_chip}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_key();
    t_enable();
    t_timeout();
    t_prio();
    t_scope();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule